// File: doc/BRIEF.md
# Bridge Driver Protection Supervisor

This block decides when the two power bridges of a dual full-bridge motor driver may conduct. It watches an active-low sleep request, a supply-good flag from an undervoltage comparator, a digital junction-temperature code and one overcurrent detect line per bridge. From these it produces three outputs:

- a single disable that covers both bridges;
- the enable of an open-drain, active-low fault pin (high means the pin pulls low);
- a ready flag that rises only after a settling interval following wake-up.

The two protection paths behave differently. An overcurrent on either bridge is latched. The latch stays set until the part is put to sleep or the supply drops. Thermal shutdown clears itself once the temperature has fallen past a hysteresis band. Both paths drive the same fault pin. An undervoltage condition blocks the bridges but raises no fault. The settling interval is a cycle counter, set by parameter, that restarts whenever the part is asleep or the supply is low.

Top module: `drv_fault_sup`

## Requirements
- R1: A high on any bit of `oc_det` (bit i is bridge i), sampled at a clock edge while `sleep_n` and `supply_ok` are both high, makes `bridge_dis` and `fault_oe` high from that edge onward.
- R2: Once set, the overcurrent state persists whatever `oc_det` and `temp_code` do. It clears only when `sleep_n` or `supply_ok` is sampled low.
- R3: A `temp_code` of TRIP_C (default 165) or above, sampled at an edge, sets thermal shutdown. From that edge both `bridge_dis` and `fault_oe` are high.
- R4: Thermal shutdown is held while `temp_code` stays at or above TRIP_C minus HYST_C (default 145). It clears at the first edge with a lower code, which releases `fault_oe`.
- R5: While `sleep_n` is low, `bridge_dis` is high and `ready` is low with no clock delay. The overcurrent state clears at the next edge.
- R6: After `sleep_n` and `supply_ok` are both high, `ready` rises at the WAKE_CYC-th rising edge that samples both high. `bridge_dis` stays high until then.
- R7: While `supply_ok` is low, `bridge_dis` is high and `ready` is low with no clock delay. The undervoltage condition never raises `fault_oe`.
- R8: `oc_det` has no effect while `sleep_n` or `supply_ok` is low: `fault_oe` stays low.
- R9: While reset is applied, `bridge_dis` is 1, `fault_oe` is 0 and `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_n | input | 1 | Low requests sleep |
| supply_ok | input | 1 | High when the motor supply is above the lockout level |
| temp_code | input | TEMP_W | Junction temperature in degrees C, unsigned |
| oc_det | input | NUM_BR | Overcurrent detect, one bit per bridge |
| bridge_dis | output | 1 | High disables both bridges |
| fault_oe | output | 1 | High pulls the open-drain fault pin low |
| ready | output | 1 | High once wake-up settling is complete |

## Verification
The hardest state to reach is an overcurrent latch that outlives a thermal event. Once the temperature falls back, the fault pin must still be held. The stimulus table first latches an overcurrent. It then drives the temperature through a full trip and release while the detect lines are quiet. Only after that does it expect sleep to clear the pin. A second hard point is the exact edge at which `ready` rises. The bench wakes the block from a known sleep and counts the edges one by one up to the rise.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic oc;
    logic hot;
  } fault_t;

  function automatic logic any_fault(input fault_t f);
    return f.oc | f.hot;
  endfunction
endpackage

// File: rtl/sup_oc_latch.sv
module sup_oc_latch #(
  parameter int NUM_BR = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              awake,
  input  logic [NUM_BR-1:0] oc_det,
  output logic              oc_q
);
  logic oc_d;

  always_comb begin
    oc_d = oc_q;
    if (!awake) oc_d = 1'b0;
    else if (|oc_det) oc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) oc_q <= 1'b0;
    else oc_q <= oc_d;
  end

  a_r1_oc_sets: assert property (@(posedge clk) disable iff (!rst_ni)
    (awake && |oc_det) |=> oc_q);
  a_r2_oc_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (oc_q && awake) |=> oc_q);
  a_r8_oc_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    !awake |=> !oc_q);
endmodule

// File: rtl/sup_thermal.sv
module sup_thermal #(
  parameter int TEMP_W = 8,
  parameter int TRIP_C = 165,
  parameter int HYST_C = 20
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot_q
);
  localparam logic [TEMP_W-1:0] SetLvl = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] ClrLvl = TEMP_W'(TRIP_C - HYST_C);

  logic hot_d;

  always_comb begin
    if (hot_q) hot_d = (temp_code >= ClrLvl);
    else       hot_d = (temp_code >= SetLvl);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) hot_q <= 1'b0;
    else hot_q <= hot_d;
  end

  a_r3_hot_trip: assert property (@(posedge clk) disable iff (!rst_ni)
    (temp_code >= SetLvl) |=> hot_q);
  a_r4_hot_band: assert property (@(posedge clk) disable iff (!rst_ni)
    (hot_q && temp_code >= ClrLvl) |=> hot_q);
  a_r4_hot_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (temp_code < ClrLvl) |=> !hot_q);
endmodule

// File: rtl/sup_wake_timer.sv
module sup_wake_timer #(
  parameter int WAKE_CYC = 375000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic awake,
  output logic ready_q
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LastCnt = CW'(WAKE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ready_d;
  logic          cnt_en;

  assign cnt_en = awake && !ready_q;

  always_comb begin
    cnt_d   = cnt_q;
    ready_d = ready_q;
    if (!awake) begin
      cnt_d   = '0;
      ready_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == LastCnt) ready_d = 1'b1;
      else cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end

  a_r6_ready_restarts: assert property (@(posedge clk) disable iff (!rst_ni)
    !awake |=> (!ready_q && cnt_q == '0));
  a_r6_no_early_ready: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ready_q && cnt_q != LastCnt) |=> !ready_q);
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup
  import sup_pkg::*;
#(
  parameter int NUM_BR   = 2,
  parameter int TEMP_W   = 8,
  parameter int TRIP_C   = 165,
  parameter int HYST_C   = 20,
  parameter int WAKE_CYC = 375000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n,
  input  logic              supply_ok,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [NUM_BR-1:0] oc_det,
  output logic              bridge_dis,
  output logic              fault_oe,
  output logic              ready
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       awake;
  logic       ready_q;
  fault_t     flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign awake = sleep_n && supply_ok;

  sup_oc_latch #(.NUM_BR(NUM_BR)) u_oc (
    .clk(clk), .rst_ni(rst_ni), .awake(awake), .oc_det(oc_det), .oc_q(flt.oc)
  );

  sup_thermal #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_th (
    .clk(clk), .rst_ni(rst_ni), .temp_code(temp_code), .hot_q(flt.hot)
  );

  sup_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wk (
    .clk(clk), .rst_ni(rst_ni), .awake(awake), .ready_q(ready_q)
  );

  assign ready      = ready_q && awake;
  assign fault_oe   = any_fault(flt);
  assign bridge_dis = !ready || fault_oe;

  a_r1_fault_blocks: assert property (@(posedge clk) disable iff (!rst_ni)
    fault_oe |-> bridge_dis);
  a_r7_uv_no_fault: assert property (@(posedge clk) disable iff (!rst_ni)
    (!supply_ok && !flt.hot) |=> !fault_oe);
  a_r9_reset_state: assert property (@(posedge clk)
    !rst_ni |-> (bridge_dis && !ready));
endmodule

// File: tb/sim_drv_fault_sup.sv
module sim_drv_fault_sup;
  localparam int WK = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_n, supply_ok;
  logic [7:0] temp_code;
  logic [1:0] oc_det;
  logic       bridge_dis, fault_oe, ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  drv_fault_sup #(.NUM_BR(2), .TEMP_W(8), .TRIP_C(165), .HYST_C(20), .WAKE_CYC(WK)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .supply_ok(supply_ok),
    .temp_code(temp_code), .oc_det(oc_det),
    .bridge_dis(bridge_dis), .fault_oe(fault_oe), .ready(ready)
  );

  // Vector layout: {sleep_n, supply_ok, temp[7:0], oc[1:0], exp_dis, exp_fault, exp_ready}
  localparam int NV = 11;
  localparam logic [14:0] VEC [NV] = '{
    {2'b11, 8'd25,  2'b00, 3'b001},  // R6 normal run
    {2'b11, 8'd164, 2'b00, 3'b001},  // R3 just below trip
    {2'b11, 8'd165, 2'b00, 3'b111},  // R3 trip
    {2'b11, 8'd150, 2'b00, 3'b111},  // R4 inside band
    {2'b11, 8'd145, 2'b00, 3'b111},  // R4 lower edge of band
    {2'b11, 8'd144, 2'b00, 3'b001},  // R4 release
    {2'b11, 8'd25,  2'b01, 3'b111},  // R1 bridge 0 overcurrent
    {2'b11, 8'd25,  2'b00, 3'b111},  // R2 latched
    {2'b11, 8'd170, 2'b00, 3'b111},  // R2 thermal on top
    {2'b11, 8'd25,  2'b00, 3'b111},  // R2 survives thermal release
    {2'b01, 8'd25,  2'b00, 3'b100}   // R5 sleep clears latch
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dis/fault/ready actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_n = 1'b1; supply_ok = 1'b1; temp_code = 8'd25; oc_det = 2'b00;
    repeat (3) step();
    chk("R9", {bridge_dis, fault_oe, ready}, 3'b100);
    rst_n = 1'b1;
    for (int i = 0; i < 40 && !ready; i++) step();
    chk("R6 bring-up", {bridge_dis, fault_oe, ready}, 3'b001);

    for (int i = 0; i < NV; i++) begin
      {sleep_n, supply_ok, temp_code, oc_det} = VEC[i][14:3];
      step();
      chk($sformatf("R1-table vec%0d", i), {bridge_dis, fault_oe, ready}, VEC[i][2:0]);
    end

    // R6: wake timing from sleep, edge by edge
    sleep_n = 1'b1;
    step();
    chk("R6 first wake edge", {bridge_dis, fault_oe, ready}, 3'b100);
    repeat (WK - 2) step();
    chk("R6 edge before ready", {bridge_dis, fault_oe, ready}, 3'b100);
    step();
    chk("R6 ready edge", {bridge_dis, fault_oe, ready}, 3'b001);

    // R1 on bridge 1
    oc_det = 2'b10;
    step();
    oc_det = 2'b00;
    chk("R1 bridge1", {bridge_dis, fault_oe, ready}, 3'b111);

    // R7: undervoltage, immediate effect
    supply_ok = 1'b0;
    #1;
    chk("R7 immediate", {bridge_dis, ready}, 3'b10);
    step();
    chk("R7 clears latch no fault", {bridge_dis, fault_oe, ready}, 3'b100);

    // R8: overcurrent ignored while supply low
    oc_det = 2'b11;
    step();
    chk("R8 supply low", {bridge_dis, fault_oe, ready}, 3'b100);

    // R8: ignored while asleep
    supply_ok = 1'b1; sleep_n = 1'b0;
    step();
    step();
    chk("R8 asleep", {bridge_dis, fault_oe, ready}, 3'b100);
    oc_det = 2'b00;

    // R5: sleep drops ready at once
    sleep_n = 1'b1;
    repeat (WK) step();
    chk("R5 pre-sleep ready", {bridge_dis, fault_oe, ready}, 3'b001);
    sleep_n = 1'b0;
    #1;
    chk("R5 immediate", {bridge_dis, fault_oe, ready}, 3'b100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule